// File: doc/BRIEF.md
# Two-Mode Supervisory Watchdog Timer

This block supervises a processor through a heartbeat line. A cycle counter runs while the processor is out of reset. Each falling edge of the heartbeat restarts the counter. If the counter reaches the selected timeout before a falling edge arrives, the block pulls its active-low reset output for a programmable number of cycles and then lets go. After the release, supervision starts again from zero.

The timeout is a base count of clock cycles. A mode input picks normal operation, which uses the base count, or extended operation, which multiplies the base count by 128. Any change on the mode input restarts the counter, so switching modes never leaves a stale count behind.

A base count of zero, or a low enable, turns supervision off. A synchronous reset request pulls the output low in the same cycle and restarts the full reset pulse. The heartbeat and mode inputs are asynchronous and pass through two-flop synchronizers. The reset request must be synchronous to the clock.

Top module: `wdt_supervisor`

## Requirements
- R1: While `rst_ni` is low, `rst_no` is low. After `rst_ni` rises, the first clock edge starts a reset pulse of the programmed length.
- R2: With no heartbeat activity, `rst_no` stays high for exactly `base_timeout_i` cycles (normal mode) after its release, and then goes low.
- R3: A reset pulse lasts exactly `rst_len_i` cycles, and a length of 0 gives a 1-cycle pulse. After the pulse, `rst_no` returns high.
- R4: A falling edge on `heartbeat_i` restarts the counter. The edge reaches the counter two clock edges after it is sampled: if the input falls before edge a, the count is zero after edge a+2. A rising edge has no effect.
- R5: A transition on `mode_ext_i` in either direction restarts the counter, with the same latency as R4.
- R6: When the synchronized `mode_ext_i` is 1, the timeout is `base_timeout_i` × 128 cycles.
- R7: When `base_timeout_i` is 0, the counter is held at zero and no timeout reset is produced.
- R8: When `enable_i` is 0, the counter is held at zero and no timeout reset is produced. Counting resumes from zero when `enable_i` returns high.
- R9: The counter is held at zero while `rst_no` is low. It counts from the first edge after `rst_no` rises.
- R10: While `rst_req_i` is high, `rst_no` is low in the same cycle. `rst_no` rises `rst_len_i` cycles after the last clock edge that saw the request.
- R11: A heartbeat clear and a timeout can fall on the same clock edge. In that case the clear wins and no reset is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-good / reset |
| rst_req_i | input | 1 | Synchronous external reset request, active high |
| heartbeat_i | input | 1 | Processor heartbeat; a falling edge restarts the counter |
| mode_ext_i | input | 1 | 0: normal timeout, 1: timeout × 128 |
| enable_i | input | 1 | Supervision enable |
| base_timeout_i | input | TW | Base timeout in cycles; 0 disables supervision |
| rst_len_i | input | RW | Reset pulse length in cycles; 0 acts as 1 |
| rst_no | output | 1 | Active-low reset to the processor |

## Verification
Two things can land on the same edge: a heartbeat clear and a timeout. To make them collide, the bench drops the heartbeat exactly two edges before the counter would expire, so that the synchronized falling edge arrives on the expiry edge. It then repeats the test one cycle later. In the first case the scoreboard expects `rst_no` to stay high and the next timeout to come one full period later. In the second case it expects the reset pulse to start on the original expiry edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned EXT_SHIFT = 7;  // extended mode: timeout x 128

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync
  import wdt_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  d_i,
  output edge_t ev_o
);
  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], d_i};
  end

  always_comb begin
    ev_o.lvl  = chain_q[STAGES-1];
    ev_o.rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    ev_o.fall = ~chain_q[STAGES-1] & chain_q[STAGES];
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          hold_i,
  input  logic          hb_fall_i,
  input  logic          mode_tog_i,
  input  logic          ext_i,
  input  logic [TW-1:0] base_i,
  output logic          timeout_o
);
  localparam int unsigned CW = TW + EXT_SHIFT;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          off;
  logic          clear;

  always_comb begin
    off       = !en_i || (base_i == '0);
    limit     = ext_i ? {base_i, {EXT_SHIFT{1'b0}}} : CW'(base_i);
    clear     = hold_i || hb_fall_i || mode_tog_i || off;
    // >= so that shrinking base_i mid-count cannot let the counter wrap
    timeout_o = !clear && (cnt_q >= limit - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear || timeout_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assert_hold_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
  assert_hb_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_fall_i |=> (cnt_q == '0));
  assert_mode_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_tog_i |=> (cnt_q == '0));
  assert_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_i == '0) |-> !timeout_o);
  assert_enable_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  assert_clear_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_fall_i |-> !timeout_o);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned RW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          timeout_i,
  input  logic [RW-1:0] len_i,
  output logic          active_o
);
  logic          por_q;
  logic [RW-1:0] rem_q;
  logic [RW-1:0] len_eff;
  logic          trig;

  always_comb begin
    len_eff  = (len_i == '0) ? RW'(1) : len_i;
    trig     = por_q || req_i || timeout_i;
    active_o = por_q || req_i || (rem_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q <= 1'b1;
      rem_q <= '0;
    end else begin
      por_q <= 1'b0;
      if (trig)              rem_q <= len_eff;
      else if (rem_q != '0)  rem_q <= rem_q - 1'b1;
    end
  end

  assert_timeout_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> (active_o && rem_q == $past(len_eff)));
  assert_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_q == RW'(1) && !trig) |=> (rem_q == '0));
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter int unsigned TW          = 16,
  parameter int unsigned RW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rst_req_i,
  input  logic          heartbeat_i,
  input  logic          mode_ext_i,
  input  logic          enable_i,
  input  logic [TW-1:0] base_timeout_i,
  input  logic [RW-1:0] rst_len_i,
  output logic          rst_no
);
  edge_t hb_ev;
  edge_t mode_ev;
  logic  timeout;
  logic  rst_active;

  wdt_sync #(.STAGES(SYNC_STAGES)) u_hb_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (heartbeat_i),
    .ev_o  (hb_ev)
  );

  wdt_sync #(.STAGES(SYNC_STAGES)) u_mode_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mode_ext_i),
    .ev_o  (mode_ev)
  );

  wdt_counter #(.TW(TW)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (enable_i),
    .hold_i    (rst_active),
    .hb_fall_i (hb_ev.fall),
    .mode_tog_i(mode_ev.rise | mode_ev.fall),
    .ext_i     (mode_ev.lvl),
    .base_i    (base_timeout_i),
    .timeout_o (timeout)
  );

  wdt_pulse #(.RW(RW)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (rst_req_i),
    .timeout_i(timeout),
    .len_i    (rst_len_i),
    .active_o (rst_active)
  );

  assign rst_no = ~rst_active;

  assert_req_immediate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> !rst_no);
  assert_timeout_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout |=> !rst_no);
endmodule

// File: tb/wdt_supervisor_tb_top.sv
`timescale 1ns/100ps
module wdt_supervisor_tb_top;
  localparam int unsigned TW = 8;
  localparam int unsigned RW = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rst_req_i = 1'b0;
  logic          heartbeat_i = 1'b0;
  logic          mode_ext_i = 1'b0;
  logic          enable_i = 1'b1;
  logic [TW-1:0] base_timeout_i = 8'd5;
  logic [RW-1:0] rst_len_i = 6'd3;
  logic          rst_no;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    c;
    bit    v;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  wdt_supervisor #(.TW(TW), .RW(RW)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .rst_req_i     (rst_req_i),
    .heartbeat_i   (heartbeat_i),
    .mode_ext_i    (mode_ext_i),
    .enable_i      (enable_i),
    .base_timeout_i(base_timeout_i),
    .rst_len_i     (rst_len_i),
    .rst_no        (rst_no)
  );

  // monitor: compare rst_no at the negedge following clock edge c
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].c <= cyc) begin
      e = q.pop_front();
      total++;
      if (e.c < cyc) begin
        bad++;
        $display("FAIL %s cycle %0d not sampled: actual=none expected=%0b", e.tag, e.c, e.v);
      end else if (rst_no !== e.v) begin
        bad++;
        $display("FAIL %s cycle %0d: actual=%0b expected=%0b", e.tag, e.c, rst_no, e.v);
      end
    end
  end

  task automatic push_exp(input int c, input bit v, input string tag);
    exp_t e;
    e.c = c; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic at_cyc(input int c);
    while (cyc < c) @(negedge clk);
    #1;
  endtask

  task automatic chk_now(input string tag, input bit act, input bit expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s direct: actual=%0b expected=%0b", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int r;
    // R1: reset state and power-up pulse
    at_cyc(2);
    chk_now("R1", rst_no, 1'b0);
    push_exp(4, 1'b0, "R1");
    push_exp(6, 1'b0, "R3");
    push_exp(7, 1'b1, "R3");
    push_exp(11, 1'b1, "R2");
    push_exp(12, 1'b0, "R2");
    push_exp(14, 1'b0, "R3");
    push_exp(15, 1'b1, "R3");
    at_cyc(3);
    rst_ni = 1'b1;
    r = 15;

    // R4: falling edge restarts the counter
    push_exp(r + 8, 1'b1, "R4");
    push_exp(r + 9, 1'b0, "R4");
    at_cyc(r);     heartbeat_i = 1'b1;
    at_cyc(r + 1); heartbeat_i = 1'b0;
    r = r + 12;

    // R4: rising edge alone does not restart
    push_exp(r + 4, 1'b1, "R4");
    push_exp(r + 5, 1'b0, "R4");
    at_cyc(r + 1); heartbeat_i = 1'b1;
    r = r + 8;

    // R11: clear lands on the expiry edge, clear wins
    push_exp(r + 5, 1'b1, "R11");
    push_exp(r + 9, 1'b1, "R11");
    push_exp(r + 10, 1'b0, "R11");
    at_cyc(r + 2); heartbeat_i = 1'b0;
    r = r + 13;

    // R11: clear one edge late, timeout fires
    push_exp(r + 4, 1'b1, "R11");
    push_exp(r + 5, 1'b0, "R11");
    at_cyc(r);     heartbeat_i = 1'b1;
    at_cyc(r + 3); heartbeat_i = 1'b0;
    r = r + 8;

    // R5: mode toggle up then down restarts the counter
    push_exp(r + 9, 1'b1, "R5");
    push_exp(r + 10, 1'b0, "R5");
    at_cyc(r + 1); mode_ext_i = 1'b1;
    at_cyc(r + 2); mode_ext_i = 1'b0;
    r = r + 13;

    // R3: programmed length 6, then length 0 acts as 1
    push_exp(r + 5, 1'b0, "R3");
    push_exp(r + 10, 1'b0, "R3");
    push_exp(r + 11, 1'b1, "R3");
    push_exp(r + 16, 1'b0, "R3");
    push_exp(r + 17, 1'b1, "R3");
    at_cyc(r);     rst_len_i = 6'd6;
    at_cyc(r + 6); rst_len_i = 6'd0;
    r = r + 17;
    at_cyc(r + 1); rst_len_i = 6'd3;

    // R8: enable low holds off the timeout
    push_exp(r + 5, 1'b1, "R8");
    push_exp(r + 100, 1'b1, "R8");
    push_exp(r + 104, 1'b1, "R8");
    push_exp(r + 105, 1'b0, "R8");
    at_cyc(r + 2);   enable_i = 1'b0;
    at_cyc(r + 100); enable_i = 1'b1;
    r = r + 108;

    // R7: base zero disables
    push_exp(r + 5, 1'b1, "R7");
    push_exp(r + 300, 1'b1, "R7");
    push_exp(r + 304, 1'b1, "R7");
    push_exp(r + 305, 1'b0, "R7");
    at_cyc(r + 1);   base_timeout_i = 8'd0;
    at_cyc(r + 300); base_timeout_i = 8'd5;
    r = r + 308;

    // R10: request asserts at once and restarts the pulse
    push_exp(r + 3, 1'b0, "R10");
    push_exp(r + 6, 1'b0, "R10");
    push_exp(r + 7, 1'b1, "R10");
    push_exp(r + 11, 1'b1, "R9");
    push_exp(r + 12, 1'b0, "R9");
    at_cyc(r + 2); rst_req_i = 1'b1;
    #0.5;
    chk_now("R10", rst_no, 1'b0);
    at_cyc(r + 4); rst_req_i = 1'b0;
    r = r + 15;

    // R6: extended mode, fresh power-up
    at_cyc(r); rst_ni = 1'b0; mode_ext_i = 1'b1;
    #0.5;
    chk_now("R1", rst_no, 1'b0);
    push_exp(r + 6 + 5, 1'b1, "R6");
    push_exp(r + 6 + 639, 1'b1, "R6");
    push_exp(r + 6 + 640, 1'b0, "R6");
    push_exp(r + 6 + 643, 1'b1, "R6");
    at_cyc(r + 2); rst_ni = 1'b1;
    at_cyc(r + 6 + 645);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule